// File: doc/BRIEF.md
# Cascadable Up/Down Decade Counter

This block is one synchronous decimal digit. It counts through the values 0 to 9, upward or downward, and wraps at either end. It can be preset from a 4-bit parallel word. An active-low enable lets it advance, and a direction input selects up or down counting. The direction can be changed on any cycle, and counting then continues the other way from the value the digit holds.

Two outputs support chaining. The terminal flag is high while the digit sits at the last value of its current direction: 9 when counting up, 0 when counting down. The active-low ripple output pulses low at terminal count, and only during the low half of the clock while the digit is enabled. A multi-digit counter is built by enabling each higher digit when every lower digit reports terminal count. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `decade_updown_counter`

## Requirements
- R1: Driving rst_n low clears count to 0 at once, with no clock edge needed. After rst_n returns high, the count stays at 0 until at least the second rising clock edge.
- R2: When load_n is low at a rising edge, count takes the value of load_data on that edge. This holds for any value of cnt_en_n and dir_down.
- R3: When load_n and cnt_en_n are both high at a rising edge, count keeps its value.
- R4: When load_n is high, cnt_en_n is low and dir_down is 0, each rising edge adds one to count, and 9 goes to 0.
- R5: When load_n is high, cnt_en_n is low and dir_down is 1, each rising edge subtracts one from count, and 0 goes to 9.
- R6: A change of dir_down applies at the next rising edge and reverses the sequence from the current count.
- R7: term_flag is high exactly when (dir_down=0 and count=9) or (dir_down=1 and count=0). It does not depend on cnt_en_n.
- R8: ripple_n is low only while term_flag is high, cnt_en_n is low and clk is low. At all other times it is high.
- R9: The values 10 to 15 can only be reached by a load. From such a value, one enabled edge gives 0 when counting up and 9 when counting down.
- R10: Two instances form a 00..99 counter, in both directions, when the higher digit's cnt_en_n is the lower digit's cnt_en_n OR NOT the lower digit's term_flag. Both instances share load_n and dir_down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_data | input | 4 | Parallel preset value |
| load_n | input | 1 | Active-low synchronous load; takes priority over counting |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| count | output | 4 | Current digit value |
| term_flag | output | 1 | High at 9 when counting up, at 0 when counting down |
| ripple_n | output | 1 | Active-low terminal pulse during the low half of clk |

## Verification
The bench runs a two-digit chain through full up and down sweeps, so every wrap at 9 and at 0 is crossed. A digit that wraps at 15, or that carries on the wrong value, would corrupt the tens digit within a few cycles. Every one of the 16 load values is applied in both directions, with enable both high and low. A design where enable masks the load, or where an illegal value stays stuck or counts to 11, fails on those steps. ripple_n is sampled in both halves of every clock period, and this catches a pulse that ignores the clock phase or the enable. A direction flip on every third cycle exposes a terminal flag tied to the wrong end of the sequence.

// File: rtl/decade_cnt_pkg.sv
package decade_cnt_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  localparam int unsigned DIGIT_W_DEF = 4;
  localparam int unsigned MODULUS_DEF = 10;
  localparam int unsigned RST_STAGES_DEF = 2;
endpackage

// File: rtl/decade_rst_sync.sv
module decade_rst_sync #(
  parameter int unsigned STAGES = decade_cnt_pkg::RST_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/decade_next.sv
module decade_next
  import decade_cnt_pkg::*;
#(
  parameter int unsigned WIDTH   = DIGIT_W_DEF,
  parameter int unsigned MODULUS = MODULUS_DEF
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_data,
  input  logic             cnt_en_n,
  input  dir_e             dir,
  output logic [WIDTH-1:0] nxt,
  output logic             upd
);
  localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] dec_val;

  always_comb begin
    // Any out-of-range value goes to 0 when counting up.
    inc_val = (cur >= TOP_VAL) ? '0 : cur + 1'b1;
    // Any out-of-range value goes to the top value when counting down.
    dec_val = ((cur == '0) || (cur > TOP_VAL)) ? TOP_VAL : cur - 1'b1;
  end

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    if (!load_n) begin
      nxt = load_data;
      upd = 1'b1;
    end else if (!cnt_en_n) begin
      upd = 1'b1;
      nxt = (dir == DIR_DOWN) ? dec_val : inc_val;
    end
  end
endmodule

// File: rtl/decade_term.sv
module decade_term
  import decade_cnt_pkg::*;
#(
  parameter int unsigned WIDTH   = DIGIT_W_DEF,
  parameter int unsigned MODULUS = MODULUS_DEF
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  output logic             term
);
  localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(MODULUS - 1);

  always_comb begin
    unique case (dir)
      DIR_UP:   term = (cur == TOP_VAL);
      DIR_DOWN: term = (cur == '0);
      default:  term = 1'b0;
    endcase
  end
endmodule

// File: rtl/decade_updown_counter.sv
module decade_updown_counter
  import decade_cnt_pkg::*;
#(
  parameter int unsigned WIDTH      = DIGIT_W_DEF,
  parameter int unsigned MODULUS    = MODULUS_DEF,
  parameter int unsigned RST_STAGES = RST_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] load_data,
  input  logic             load_n,
  input  logic             cnt_en_n,
  input  logic             dir_down,
  output logic [WIDTH-1:0] count,
  output logic             term_flag,
  output logic             ripple_n
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_upd;
  dir_e             dir;

  assign dir = dir_e'(dir_down);

  decade_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  decade_next #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_next (
    .cur       (cnt_q),
    .load_n    (load_n),
    .load_data (load_data),
    .cnt_en_n  (cnt_en_n),
    .dir       (dir),
    .nxt       (cnt_d),
    .upd       (cnt_upd)
  );

  decade_term #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_term (
    .cur  (cnt_q),
    .dir  (dir),
    .term (term_flag)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_d;
  end

  assign count    = cnt_q;
  // Pulses only in the low clock phase, after the count has settled.
  assign ripple_n = ~(term_flag & ~cnt_en_n & ~clk);
endmodule

// File: rtl/decade_updown_counter_chk.sv
module decade_updown_counter_chk #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned MODULUS = 10
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic [WIDTH-1:0] load_data,
  input logic             load_n,
  input logic             cnt_en_n,
  input logic             dir_down,
  input logic [WIDTH-1:0] count,
  input logic             term_flag,
  input logic             ripple_n
);
  localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(MODULUS - 1);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !load_n |=> count == $past(load_data)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (load_n && cnt_en_n) |=> $stable(count)); // R3

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (load_n && !cnt_en_n && !dir_down && count < TOP_VAL) |=> count == $past(count) + 1'b1); // R4

  AST_TERM_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (load_n && !cnt_en_n && !dir_down && term_flag) |=> count == '0); // R4

  AST_TERM_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (load_n && !cnt_en_n && dir_down && term_flag) |=> count == TOP_VAL); // R5

  AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (load_n && !cnt_en_n && count > TOP_VAL) |=> count <= TOP_VAL); // R9

  AST_RIPPLE_IDLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    cnt_en_n |-> ripple_n); // R8
endmodule

bind decade_updown_counter decade_updown_counter_chk #(
  .WIDTH   (WIDTH),
  .MODULUS (MODULUS)
) u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .load_data (load_data),
  .load_n    (load_n),
  .cnt_en_n  (cnt_en_n),
  .dir_down  (dir_down),
  .count     (count),
  .term_flag (term_flag),
  .ripple_n  (ripple_n)
);

// File: tb/decade_updown_counter_bench.sv
module decade_updown_counter_bench;
  logic       clk;
  logic       rst_n;
  logic       load_n;
  logic       en_n;
  logic       dir_down;
  logic [3:0] u_data;
  logic [3:0] t_data;
  logic [3:0] u_cnt;
  logic [3:0] t_cnt;
  logic       u_term;
  logic       t_term;
  logic       u_rip;
  logic       t_rip;
  logic       t_en_n;

  int checks;
  int failures;
  int ue;
  int te;

  // Chaining rule for the higher digit (R10)
  assign t_en_n = en_n | ~u_term;

  decade_updown_counter u_decade_updown_counter (
    .clk(clk), .rst_n(rst_n), .load_data(u_data), .load_n(load_n),
    .cnt_en_n(en_n), .dir_down(dir_down), .count(u_cnt),
    .term_flag(u_term), .ripple_n(u_rip)
  );

  decade_updown_counter u_tens (
    .clk(clk), .rst_n(rst_n), .load_data(t_data), .load_n(load_n),
    .cnt_en_n(t_en_n), .dir_down(dir_down), .count(t_cnt),
    .term_flag(t_term), .ripple_n(t_rip)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int step(input int v, input logic dn);
    if (dn) return (v == 0 || v > 9) ? 9 : v - 1;
    return (v >= 9) ? 0 : v + 1;
  endfunction

  function automatic logic term_of(input int v, input logic dn);
    return dn ? (v == 0) : (v == 9);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Applies inputs for one clock; called in the low clock phase.
  task automatic cyc(input logic ld, input logic [3:0] ud, input logic [3:0] td,
                     input logic en, input logic dn, input string req);
    logic t_go;
    logic ut;
    logic tt;
    load_n = ld; u_data = ud; t_data = td; en_n = en; dir_down = dn;
    t_go = !en && term_of(ue, dn);
    @(posedge clk);
    if (!ld) begin
      ue = ud; te = td;
    end else begin
      if (!en) ue = step(ue, dn);
      if (t_go) te = step(te, dn);
    end
    ut = term_of(ue, dn);
    tt = term_of(te, dn);
    #1;
    chk({req, " units count"}, u_cnt, ue);
    chk({req, " tens count"}, t_cnt, te);
    chk({req, " R7 units term"}, u_term, ut);
    chk({req, " R7 tens term"}, t_term, tt);
    #1;
    chk("R8 units ripple high phase", u_rip, 1);
    chk("R8 tens ripple high phase", t_rip, 1);
    #5;
    chk("R8 units ripple low phase", u_rip, !(ut && !en));
    chk("R8 tens ripple low phase", t_rip, !(tt && !en && ut));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; ue = 0; te = 0;
    load_n = 1'b1; en_n = 1'b1; dir_down = 1'b0; u_data = '0; t_data = '0;
    rst_n = 1'b0;
    #23 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #6;
    chk("R1 reset units", u_cnt, 0);
    chk("R1 reset tens", t_cnt, 0);
    chk("R7 reset term up", u_term, 0);

    // Full upward sweep past 99 (R4, R10)
    for (int i = 0; i < 105; i++) cyc(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, "R4 R10");
    // Full downward sweep past 00 (R5, R10)
    for (int i = 0; i < 125; i++) cyc(1'b1, 4'd0, 4'd0, 1'b0, 1'b1, "R5 R10");
    // Direction flips mid-sequence (R6)
    for (int i = 0; i < 24; i++) cyc(1'b1, 4'd0, 4'd0, 1'b0, (i % 3) == 0, "R6");
    // Hold with direction wiggling (R3)
    for (int i = 0; i < 8; i++) cyc(1'b1, 4'd0, 4'd0, 1'b1, i[0], "R3");
    // Every load value, both directions, enable both ways, then count on (R2, R9)
    for (int v = 0; v < 16; v++) begin
      for (int d = 0; d < 2; d++) begin
        cyc(1'b0, 4'(v), 4'(15 - v), v[0], d[0], "R2");
        cyc(1'b1, 4'd0, 4'd0, 1'b0, d[0], "R9");
        cyc(1'b1, 4'd0, 4'd0, 1'b0, d[0], "R9");
      end
    end

    // Asynchronous reset in mid-run (R1)
    rst_n = 1'b0;
    #1;
    chk("R1 async clear units", u_cnt, 0);
    chk("R1 async clear tens", t_cnt, 0);
    ue = 0; te = 0;
    @(negedge clk);
    rst_n = 1'b1;
    en_n = 1'b0; dir_down = 1'b0; load_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 held after release", u_cnt, 0);
    en_n = 1'b1;
    @(posedge clk); #6;
    cyc(1'b1, 4'd0, 4'd0, 1'b0, 1'b0, "R4 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule